// File: doc/BRIEF.md
# Local Interrupt Selector

This block picks the local interrupt that a hart should service in the current cycle. It holds the interrupt-pending register and takes the enable register, the delegation mask, the current privilege level and the two global enable bits (machine and supervisor) as plain control inputs. Each pending and enabled bit is then admitted or blocked. Bits that are not delegated are controlled by the machine-level enable. Delegated bits are controlled by the supervisor-level enable. The lowest-numbered surviving bit is reported with a valid flag.

The pending register changes only through a masked update port. On an accepted update, the bits selected by the mask take the new value and the other bits keep their contents. The port has no back-pressure: an update presented with `upd_valid` high is always taken on that clock edge, so there is no ready signal.

A hard-interrupt request line follows the pending register. It rises on the edge at which the register goes from all-zero to nonzero. It falls on the edge at which the register returns to zero. The selection path is purely combinational from the register and the control inputs.

Top module: `irq_select_top`

## Requirements
- R1: After reset is asserted (active-low `rst_n`), `pend_q` is zero, `hard_req` is 0, `take_valid` is 0 and `take_num` is 0.
- R2: When `upd_valid` is 1 at a rising clock edge, `pend_q` becomes (old AND NOT `upd_mask`) OR (`upd_value` AND `upd_mask`). When `upd_valid` is 0, `pend_q` keeps its value whatever `upd_mask` and `upd_value` carry.
- R3: `hard_req` is set on the edge where `pend_q` goes from zero to nonzero. It is cleared on the edge where `pend_q` goes from nonzero to zero, and it holds otherwise.
- R4: Only bits set in both `pend_q` and `ie_mask` can be selected. A pending bit with its enable at 0 is never reported.
- R5: A candidate whose `deleg_mask` bit is 0 is admitted when `cur_priv` is below machine, or when `cur_priv` is machine and `m_gie` is 1. Privilege codes are U=0, S=1 and M=3. The code 2 counts as below machine and not below supervisor.
- R6: A candidate whose `deleg_mask` bit is 1 is admitted when `cur_priv` is U, or when `cur_priv` is S and `s_gie` is 1. A delegated bit is never admitted at machine privilege or at code 2.
- R7: `take_num` is the index of the lowest admitted bit and `take_valid` is 1. When no bit is admitted, `take_valid` is 0 and `take_num` is 0.
- R8: The selection has no register stage. A change on `ie_mask`, `deleg_mask`, `cur_priv`, `m_gie` or `s_gie` shows on `take_valid` and `take_num` without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ie_mask | input | 32 | Per-interrupt enable bits |
| deleg_mask | input | 32 | 1 = interrupt handled at supervisor level |
| cur_priv | input | 2 | Current privilege (U=0, S=1, M=3) |
| m_gie | input | 1 | Global machine interrupt enable |
| s_gie | input | 1 | Global supervisor interrupt enable |
| upd_valid | input | 1 | Apply a masked update at this edge |
| upd_mask | input | 32 | Bits of the pending register to replace |
| upd_value | input | 32 | New values for the masked bits |
| pend_q | output | 32 | Current pending register |
| take_valid | output | 1 | An interrupt is selected |
| take_num | output | 5 | Index of the selected interrupt |
| hard_req | output | 1 | Hard-interrupt request line |

## Verification
Two functions can act on the same clock edge: a masked update that clears the interrupt currently being selected, and a change in the request line. The bench drives an update that removes the selected bit while other bits stay pending. It checks that the selection moves to the next higher bit and that `hard_req` stays high. It then drives an update that clears every remaining bit. On that edge it checks that `take_valid` and `hard_req` both drop. The update and the selection are read back at the ports one time unit after the edge.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;
endpackage

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
  parameter int NUM_IRQ = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               upd_valid,
  input  logic [NUM_IRQ-1:0] upd_mask,
  input  logic [NUM_IRQ-1:0] upd_value,
  output logic [NUM_IRQ-1:0] pend_q,
  output logic               hard_req
);
  logic [NUM_IRQ-1:0] pend_nxt;
  logic               rise, fall;

  always_comb begin
    pend_nxt = pend_q;
    if (upd_valid) pend_nxt = (pend_q & ~upd_mask) | (upd_value & upd_mask);
    rise = (pend_q == '0) && (pend_nxt != '0);
    fall = (pend_q != '0) && (pend_nxt == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= '0;
      hard_req <= 1'b0;
    end else begin
      pend_q <= pend_nxt;
      if (rise)      hard_req <= 1'b1;
      else if (fall) hard_req <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_gate.sv
module irq_gate
  import irq_sel_pkg::*;
#(
  parameter int NUM_IRQ = 32
) (
  input  logic [NUM_IRQ-1:0] pend,
  input  logic [NUM_IRQ-1:0] ie_mask,
  input  logic [NUM_IRQ-1:0] deleg_mask,
  input  logic [1:0]         cur_priv,
  input  logic               m_gie,
  input  logic               s_gie,
  output logic [NUM_IRQ-1:0] admitted
);
  logic m_en, s_en;
  logic [NUM_IRQ-1:0] cand;

  always_comb begin
    m_en = (cur_priv < PRIV_M) || ((cur_priv == PRIV_M) && m_gie);
    s_en = (cur_priv < PRIV_S) || ((cur_priv == PRIV_S) && s_gie);
    cand = pend & ie_mask;
    admitted = (cand & ~deleg_mask & {NUM_IRQ{m_en}})
             | (cand &  deleg_mask & {NUM_IRQ{s_en}});
  end
endmodule

// File: rtl/irq_lsb_pick.sv
module irq_lsb_pick #(
  parameter int NUM_IRQ = 32,
  localparam int IDW = $clog2(NUM_IRQ)
) (
  input  logic [NUM_IRQ-1:0] bits,
  output logic               found,
  output logic [IDW-1:0]     idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (bits[i]) begin
        found = 1'b1;
        idx   = IDW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_select_top.sv
module irq_select_top #(
  parameter int NUM_IRQ = 32,
  localparam int IDW = $clog2(NUM_IRQ)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] ie_mask,
  input  logic [NUM_IRQ-1:0] deleg_mask,
  input  logic [1:0]         cur_priv,
  input  logic               m_gie,
  input  logic               s_gie,
  input  logic               upd_valid,
  input  logic [NUM_IRQ-1:0] upd_mask,
  input  logic [NUM_IRQ-1:0] upd_value,
  output logic [NUM_IRQ-1:0] pend_q,
  output logic               take_valid,
  output logic [IDW-1:0]     take_num,
  output logic               hard_req
);
  logic [NUM_IRQ-1:0] admitted;

  irq_pend_reg #(.NUM_IRQ(NUM_IRQ)) pend_i (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_mask(upd_mask),
    .upd_value(upd_value), .pend_q(pend_q), .hard_req(hard_req)
  );

  irq_gate #(.NUM_IRQ(NUM_IRQ)) gate_i (
    .pend(pend_q), .ie_mask(ie_mask), .deleg_mask(deleg_mask),
    .cur_priv(cur_priv), .m_gie(m_gie), .s_gie(s_gie), .admitted(admitted)
  );

  irq_lsb_pick #(.NUM_IRQ(NUM_IRQ)) pick_i (
    .bits(admitted), .found(take_valid), .idx(take_num)
  );
endmodule

// File: rtl/irq_select_chk.sv
module irq_select_chk #(
  parameter int NUM_IRQ = 32,
  localparam int IDW = $clog2(NUM_IRQ)
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_IRQ-1:0] ie_mask,
  input logic [NUM_IRQ-1:0] deleg_mask,
  input logic [1:0]         cur_priv,
  input logic               m_gie,
  input logic               upd_valid,
  input logic [NUM_IRQ-1:0] upd_mask,
  input logic [NUM_IRQ-1:0] upd_value,
  input logic [NUM_IRQ-1:0] pend_q,
  input logic               take_valid,
  input logic [IDW-1:0]     take_num,
  input logic               hard_req
);
  // R2
  masked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> pend_q == (($past(pend_q) & ~$past(upd_mask)) | ($past(upd_value) & $past(upd_mask))));

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(pend_q));

  // R3
  req_tracks_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hard_req == (pend_q != '0));

  // R4
  sel_is_candidate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid |-> (pend_q[take_num] && ie_mask[take_num]));

  // R5
  m_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_priv == 2'd3 && !m_gie) |-> !take_valid);

  // R6
  no_deleg_in_m_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_valid && cur_priv == 2'd3) |-> !deleg_mask[take_num]);

  // R7
  idle_num_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take_valid |-> take_num == '0);
endmodule

bind irq_select_top irq_select_chk #(.NUM_IRQ(NUM_IRQ)) chk_i (.*);

// File: tb/irq_select_top_tb_top.sv
module irq_select_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ie_mask = '0, deleg_mask = '0, upd_mask = '0, upd_value = '0;
  logic [1:0]  cur_priv = 2'd3;
  logic        m_gie = 1'b0, s_gie = 1'b0, upd_valid = 1'b0;
  logic [31:0] pend_q;
  logic        take_valid, hard_req;
  logic [4:0]  take_num;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_select_top dut_i (.*);

  typedef struct packed {
    logic [31:0] pend; logic [31:0] ie; logic [31:0] deleg;
    logic [1:0] priv; logic mgie; logic sgie; logic ev; logic [4:0] en;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{32'h0000_0880, 32'hFFFF_FFFF, 32'h0, 2'd3, 1'b1, 1'b0, 1'b1, 5'd7},
    '{32'h0000_0880, 32'hFFFF_FFFF, 32'h0, 2'd3, 1'b0, 1'b0, 1'b0, 5'd0},
    '{32'h0000_0880, 32'hFFFF_FFFF, 32'h0, 2'd1, 1'b0, 1'b0, 1'b1, 5'd7},
    '{32'h0000_0222, 32'hFFFF_FFFF, 32'h222, 2'd3, 1'b1, 1'b1, 1'b0, 5'd0},
    '{32'h0000_0222, 32'hFFFF_FFFF, 32'h222, 2'd1, 1'b1, 1'b0, 1'b0, 5'd0},
    '{32'h0000_0222, 32'hFFFF_FFFF, 32'h222, 2'd1, 1'b0, 1'b1, 1'b1, 5'd1},
    '{32'h0000_0222, 32'hFFFF_FFFF, 32'h222, 2'd0, 1'b0, 1'b0, 1'b1, 5'd1},
    '{32'h0000_0222, 32'hFFFF_FFFF, 32'h002, 2'd1, 1'b0, 1'b0, 1'b1, 5'd5},
    '{32'h8000_0000, 32'h8000_0000, 32'h0, 2'd0, 1'b0, 1'b0, 1'b1, 5'd31},
    '{32'hFFFF_FFFF, 32'hFFFF_FFFE, 32'h0, 2'd3, 1'b1, 1'b0, 1'b1, 5'd1},
    '{32'h0000_0010, 32'h0000_0000, 32'h0, 2'd0, 1'b1, 1'b1, 1'b0, 5'd0},
    '{32'h0000_0006, 32'hFFFF_FFFF, 32'h002, 2'd2, 1'b0, 1'b1, 1'b1, 5'd2}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] m, input logic [31:0] v);
    @(negedge clk);
    upd_valid = 1'b1; upd_mask = m; upd_value = v;
    @(posedge clk); #1;
    upd_valid = 1'b0;
  endtask

  task automatic chk_sel(input string tag, input logic ev, input logic [4:0] en);
    chk({tag, " valid"}, {31'b0, take_valid}, {31'b0, ev});
    chk({tag, " num"}, {27'b0, take_num}, {27'b0, en});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    ie_mask = '1; m_gie = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 pend", pend_q, 32'h0);
    chk("R1 req", {31'b0, hard_req}, 32'h0);
    chk_sel("R1", 1'b0, 5'd0);
    @(negedge clk); rst_n = 1'b1;

    // R4 R5 R6 R7 table walk
    foreach (VECS[i]) begin
      wr(32'hFFFF_FFFF, VECS[i].pend);
      ie_mask = VECS[i].ie; deleg_mask = VECS[i].deleg; cur_priv = VECS[i].priv;
      m_gie = VECS[i].mgie; s_gie = VECS[i].sgie;
      #1;
      chk_sel($sformatf("R7 vec%0d", i), VECS[i].ev, VECS[i].en);
      chk($sformatf("R3 vec%0d", i), {31'b0, hard_req}, 32'h1);
    end

    // R2 partial masked update
    ie_mask = '1; deleg_mask = '0; cur_priv = 2'd3; m_gie = 1'b1;
    wr(32'hFFFF_FFFF, 32'hF0F0_0000);
    wr(32'h00FF_0000, 32'h0012_3456);
    chk("R2 masked", pend_q, 32'hF012_0000);
    // R2 ignored when upd_valid low
    @(negedge clk); upd_mask = '1; upd_value = 32'h0;
    @(posedge clk); #1;
    chk("R2 idle hold", pend_q, 32'hF012_0000);

    // R3 clear to zero then raise
    wr(32'hFFFF_FFFF, 32'h0);
    chk("R3 fall", {31'b0, hard_req}, 32'h0);
    chk_sel("R7 empty", 1'b0, 5'd0);
    wr(32'h0000_0001, 32'hFFFF_FFFF);
    chk("R3 rise", {31'b0, hard_req}, 32'h1);
    chk("R2 single bit", pend_q, 32'h1);

    // Same edge: clear the selected bit while others remain
    wr(32'hFFFF_FFFF, 32'h0000_0048);
    chk_sel("R7 before", 1'b1, 5'd3);
    wr(32'h0000_0008, 32'h0);
    chk_sel("R7 next", 1'b1, 5'd6);
    chk("R3 stays", {31'b0, hard_req}, 32'h1);
    wr(32'h0000_0040, 32'h0);
    chk_sel("R7 drained", 1'b0, 5'd0);
    chk("R3 drop", {31'b0, hard_req}, 32'h0);

    // R8 combinational response to enables
    wr(32'hFFFF_FFFF, 32'h0000_0100);
    @(negedge clk); m_gie = 1'b0; #1;
    chk_sel("R8 m off", 1'b0, 5'd0);
    m_gie = 1'b1; #1;
    chk_sel("R8 m on", 1'b1, 5'd8);
    ie_mask = 32'hFFFF_FEFF; #1;
    chk_sel("R4 ie off", 1'b0, 5'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule